// File: doc/BRIEF.md
# Static Memory Zone Bus Sequencer

This block drives one chip-select zone of an external static memory bus. An internal master issues a read or write request carrying a byte address, a size (byte or 16-bit word), write data and a zone tag. The sequencer runs the external cycle, with select, address, write data, a read strobe, a write strobe and a narrow-lane flag. For reads it returns the assembled data together with a one-cycle done pulse. A 16-bit configuration register sets the timing: internal wait states, hold cycles, the external bus width, a fast one-cycle read, byte-pair burst reads with an optional burst wait, and idle cycles placed around a change of zone.

The master holds `req_valid` for one cycle while the sequencer is idle. It may issue the next request only after the done pulse. The timing fields are captured when a request is accepted, so a configuration write affects the next access.

Top module: `static_zone_seq`

## Requirements
- R1: The configuration register resets to 0x069F. Its fields are WAIT[2:0], HOLD[4:3], RBE[5], WBR[6], BW[7], FRE[8], IPRE[9] and IPST[10]. Bits [15:11] always read as zero, and writes to them have no effect.
- R2: A normal byte or word cycle takes 2+WAIT+HOLD clocks. It has one setup cycle, 1+WAIT strobe cycles and HOLD hold cycles. `done` rises in the clock after the last bus cycle, so a request without idle cycles finishes in cycle 1+(bus cycles) after the accepting edge.
- R3: When FRE=1, every read bus cycle is a single strobe cycle with no setup and no hold. WAIT, HOLD, RBE and WBR are ignored. Writes keep normal timing whatever FRE is.
- R4: With BW=1, a word moves in one bus cycle on the full data bus with `bus_narrow`=0. A byte uses lane [7:0] with `bus_narrow`=1, and its read result is zero-extended.
- R5: A word access to an 8-bit zone (BW=0) without a burst runs as two complete byte cycles. The first is at the even address and carries the low byte. The second is at the even address plus one and carries the high byte.
- R6: A word read with BW=0, RBE=1 and FRE=0 runs as a burst. Select stays high from the setup cycle to the end of hold, and the second byte adds 1+WBR strobe cycles, for a total of 3+WAIT+WBR+HOLD clocks. RBE has no effect when BW=1.
- R7: WBR adds exactly one strobe cycle to a burst read and changes nothing when RBE=0.
- R8: When a request's zone differs from the previous one, the sequencer inserts IPRE (current setting) plus IPST (setting captured at the previous access) idle cycles before the first bus cycle, with select low. With the same zone it inserts none.
- R9: `req_valid` is ignored from the accepting edge through the done cycle. A request raised then causes no bus cycle, no memory change and no done pulse. `done` lasts exactly one cycle.
- R10: Reset clears the last-zone record to zone 0 and its post-idle flag to 0, so a first access to zone 0 gets no idle cycles.
- R11: Write data reaches memory as specified in R4 and R5 and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register contents |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_zone | input | ZONE_W | Zone tag of the request |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| bus_sel | output | 1 | External zone select |
| bus_addr | output | ADDR_W | External byte address |
| bus_wdata | output | 16 | External write data |
| bus_narrow | output | 1 | Only lane [7:0] carries data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | External read data |

## Verification
Each access is scored on three things: its latency in clocks, the number of strobe cycles it produced, and its read data. Together these separate wait cycles from hold cycles, and they separate a burst from a split pair of byte cycles. The tests cover byte and word reads on both bus widths, split and burst word reads with and without the burst wait, and fast reads with large wait and hold values (to show those fields are ignored). Writes are checked by reading back through the model memory. A run of zone changes under every combination of pre-idle and post-idle settings shows how the count of idle cycles is formed. A write request raised in the middle of a long access must leave memory and the done stream untouched.

// File: rtl/sz_pkg.sv
package sz_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int CFG_W  = 16;
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h069F;
    localparam logic [CFG_W-1:0] CFG_MASK  = 16'h07FF;

    // Packed so that the struct maps onto register bits [10:0].
    typedef struct packed {
        logic       ipst;
        logic       ipre;
        logic       fre;
        logic       bw;
        logic       wbr;
        logic       rbe;
        logic [1:0] hold;
        logic [2:0] wait_n;
    } tim_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_T1,
        S_STRB,
        S_HOLD,
        S_DONE
    } st_t;

    function automatic tim_t to_tim(input logic [CFG_W-1:0] r);
        return tim_t'(r[10:0]);
    endfunction
endpackage

// File: rtl/sz_cfg_reg.sv
module sz_cfg_reg
    import sz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output tim_t             tim
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = wdata & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign rdata = cfg_q;
    assign tim   = to_tim(cfg_q);
endmodule

// File: rtl/sz_zone_track.sv
module sz_zone_track #(
    parameter int ZONE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ZONE_W-1:0] zone,
    input  logic              ipre,
    input  logic              ipst,
    output logic [1:0]        gaps
);
    typedef struct packed {
        logic [ZONE_W-1:0] zone;
        logic              post;
    } trk_t;

    trk_t trk_d, trk_q;
    logic change;

    always_comb begin
        change = (zone != trk_q.zone);
        gaps   = change ? ({1'b0, ipre} + {1'b0, trk_q.post}) : 2'd0;
        trk_d  = trk_q;
        if (accept) begin
            trk_d.zone = zone;
            trk_d.post = ipst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/sz_seq.sv
module sz_seq
    import sz_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  tim_t              tim,
    input  logic [1:0]        gaps,
    output logic              accept,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_narrow,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        st_t               st;
        logic [2:0]        cnt;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              word;
        logic              fast;
        logic              burst;
        logic              split;
        logic              phase;
        logic              bw;
        logic              wbr;
        logic [1:0]        hold;
        logic [2:0]        wait_n;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t q, n;
    logic unit_end;
    logic fast_in;

    always_comb begin
        n        = q;
        accept   = 1'b0;
        unit_end = 1'b0;
        fast_in  = tim.fre & ~req_write;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    n.write  = req_write;
                    n.word   = req_word;
                    n.fast   = fast_in;
                    n.split  = req_word & ~tim.bw;
                    n.burst  = ~fast_in & ~req_write & req_word & ~tim.bw & tim.rbe;
                    n.bw     = tim.bw;
                    n.wbr    = tim.wbr;
                    n.hold   = tim.hold;
                    n.wait_n = tim.wait_n;
                    n.addr   = req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
                    n.phase  = 1'b0;
                    n.wdata  = req_wdata;
                    n.rdata  = '0;
                    if (gaps != 2'd0) begin
                        n.st  = S_GAP;
                        n.cnt = {1'b0, gaps - 2'd1};
                    end else begin
                        n.st  = fast_in ? S_STRB : S_T1;
                        n.cnt = '0;
                    end
                end
            end
            S_GAP: begin
                if (q.cnt == '0) n.st = q.fast ? S_STRB : S_T1;
                else             n.cnt = q.cnt - 3'd1;
            end
            S_T1: begin
                n.st  = S_STRB;
                n.cnt = q.wait_n;
            end
            S_STRB: begin
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - 3'd1;
                end else begin
                    if (!q.write) begin
                        if (q.split) begin
                            if (q.phase) n.rdata[DATA_W-1:BYTE_W] = bus_rdata[BYTE_W-1:0];
                            else         n.rdata[BYTE_W-1:0]      = bus_rdata[BYTE_W-1:0];
                        end else if (q.word) begin
                            n.rdata = bus_rdata;
                        end else begin
                            n.rdata = {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
                        end
                    end
                    if (q.burst && !q.phase) begin
                        n.phase = 1'b1;
                        n.addr  = q.addr + ONE;
                        n.cnt   = {2'b00, q.wbr};
                    end else if (!q.fast && q.hold != 2'd0) begin
                        n.st  = S_HOLD;
                        n.cnt = {1'b0, q.hold - 2'd1};
                    end else begin
                        unit_end = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (q.cnt == '0) unit_end = 1'b1;
                else             n.cnt = q.cnt - 3'd1;
            end
            S_DONE: n.st = S_IDLE;
            default: n.st = S_IDLE;
        endcase

        if (unit_end) begin
            if (q.split && !q.burst && !q.phase) begin
                n.phase = 1'b1;
                n.addr  = q.addr + ONE;
                n.st    = q.fast ? S_STRB : S_T1;
                n.cnt   = '0;
            end else begin
                n.st = S_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        bus_sel    = (q.st == S_T1) || (q.st == S_STRB) || (q.st == S_HOLD);
        bus_rd     = (q.st == S_STRB) && !q.write;
        bus_wr     = (q.st == S_STRB) && q.write;
        bus_addr   = q.addr;
        bus_narrow = !(q.word && q.bw);
        if (q.split)
            bus_wdata = {{(DATA_W-BYTE_W){1'b0}},
                         q.phase ? q.wdata[DATA_W-1:BYTE_W] : q.wdata[BYTE_W-1:0]};
        else if (q.word)
            bus_wdata = q.wdata;
        else
            bus_wdata = {{(DATA_W-BYTE_W){1'b0}}, q.wdata[BYTE_W-1:0]};
        done  = (q.st == S_DONE);
        rdata = q.rdata;
    end
endmodule

// File: rtl/static_zone_seq.sv
module static_zone_seq #(
    parameter int ADDR_W = 16,
    parameter int ZONE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ZONE_W-1:0] req_zone,
    input  logic [15:0]       req_wdata,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              bus_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    output logic              bus_narrow,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [15:0]       bus_rdata
);
    sz_pkg::tim_t tim;
    logic [1:0]   gaps;
    logic         accept;

    sz_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .tim   (tim)
    );

    sz_zone_track #(.ZONE_W(ZONE_W)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .zone   (req_zone),
        .ipre   (tim.ipre),
        .ipst   (tim.ipst),
        .gaps   (gaps)
    );

    sz_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .tim        (tim),
        .gaps       (gaps),
        .accept     (accept),
        .done       (done),
        .rdata      (rdata),
        .bus_sel    (bus_sel),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_narrow (bus_narrow),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/sz_chk.sv
module sz_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        bus_sel,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [15:0] cfg_rdata
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:11] == 5'd0);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_sel);

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R2
    done_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_sel);
endmodule

bind static_zone_seq sz_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/sim_static_zone_seq.sv
module sim_static_zone_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_zone = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        bus_sel;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_narrow;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_rdata;

    static_zone_seq u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] ma;
    assign ma = bus_addr[7:0];
    assign bus_rdata = {mem[ma + 8'd1], mem[ma]};
    always @(posedge clk) begin
        if (bus_wr) begin
            mem[ma] <= bus_wdata[7:0];
            if (!bus_narrow) mem[ma + 8'd1] <= bus_wdata[15:8];
        end
    end

    typedef struct {
        logic [15:0] rd;
        bit          chk_rd;
        int          lat;
        int          strb;
        string       tag;
    } exp_t;
    exp_t q[$];

    int cyc = 0, nchk = 0, nfail = 0;
    int t0 = 0, scnt = 0, sc0 = 0;
    logic [15:0] cfg_sh = 16'h069F;
    logic [2:0]  lastz = 3'd0;
    bit          lastpost = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd || bus_wr) scnt++;
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc - t0 == e.lat, {e.tag, " latency"}, cyc - t0, e.lat);
                    chk(scnt - sc0 == e.strb, {e.tag, " strobes"}, scnt - sc0, e.strb);
                    if (e.chk_rd) chk(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == LIMIT) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    task automatic setcfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_sh = v & 16'h07FF;
    endtask

    task automatic acc(input bit wr, input bit wd, input logic [15:0] ad,
                       input logic [2:0] z, input logic [15:0] wdat,
                       input string tag, input bit intrude);
        int w, h, unit, sunit, units, strb, gaps;
        bit fast, split, burst;
        logic [7:0] a;
        exp_t e;
        w = int'(cfg_sh[2:0]);
        h = int'(cfg_sh[4:3]);
        fast  = cfg_sh[8] && !wr;
        split = wd && !cfg_sh[7];
        burst = !fast && !wr && wd && !cfg_sh[7] && cfg_sh[5];
        unit  = fast ? 1 : 2 + w + h;
        sunit = fast ? 1 : 1 + w;
        if (burst) begin
            units = 3 + w + int'(cfg_sh[6]) + h;
            strb  = 2 + w + int'(cfg_sh[6]);
        end else if (split) begin
            units = 2 * unit;
            strb  = 2 * sunit;
        end else begin
            units = unit;
            strb  = sunit;
        end
        gaps = (z != lastz) ? int'(cfg_sh[9]) + int'(lastpost) : 0;
        lastz = z;
        lastpost = cfg_sh[10];
        a = wd ? {ad[7:1], 1'b0} : ad[7:0];
        e.lat = gaps + units + 1;
        e.strb = strb;
        e.tag = tag;
        e.chk_rd = !wr;
        e.rd = wd ? {exp_mem[a + 8'd1], exp_mem[a]} : {8'h00, exp_mem[a]};
        if (wr) begin
            exp_mem[a] = wdat[7:0];
            if (wd) exp_mem[a + 8'd1] = wdat[15:8];
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_word  = wd;
        req_addr  = ad;
        req_zone  = z;
        req_wdata = wdat;
        t0  = cyc;
        sc0 = scnt;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b1;
            req_word  = 1'b1;
            req_addr  = 16'h0080;
            req_zone  = 3'd7;
            req_wdata = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        // R1 reset value, R9 idle outputs
        chk(cfg_rdata == 16'h069F, "R1 reset cfg", cfg_rdata, 16'h069F);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(bus_sel == 1'b0, "R2 reset select", bus_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 first access to zone 0: no idle; R2 R4 word on 16-bit bus
        acc(0, 1, 16'h0010, 3'd0, 0, "R10 R2 R4 default word", 0);
        // R8 zone change: pre + post = 2 idle cycles
        acc(0, 0, 16'h0021, 3'd1, 0, "R8 R4 byte zone change", 0);
        acc(0, 0, 16'h0022, 3'd1, 0, "R8 same zone", 0);
        setcfg(16'h0480);
        acc(0, 0, 16'h0030, 3'd2, 0, "R8 post only", 0);
        setcfg(16'h0080);
        acc(0, 0, 16'h0031, 3'd3, 0, "R8 prior post flag", 0);
        setcfg(16'h0280);
        acc(0, 0, 16'h0032, 3'd4, 0, "R8 pre only", 0);
        setcfg(16'h0680);
        acc(0, 0, 16'h0033, 3'd5, 0, "R8 pre with no post", 0);
        acc(0, 0, 16'h0034, 3'd6, 0, "R8 pre plus post", 0);
        // short timing, odd byte on wide bus
        setcfg(16'h0081);
        acc(0, 0, 16'h0043, 3'd6, 0, "R4 R2 odd byte", 0);
        // fast read overrides wait and hold
        setcfg(16'h019F);
        acc(0, 1, 16'h0050, 3'd6, 0, "R3 fast word", 0);
        acc(1, 1, 16'h0060, 3'd6, 16'hBEEF, "R3 write keeps normal timing", 0);
        acc(0, 1, 16'h0060, 3'd6, 0, "R11 readback wide", 0);
        // 8-bit bus split
        setcfg(16'h000A);
        acc(0, 1, 16'h0071, 3'd6, 0, "R5 split word", 0);
        setcfg(16'h004A);
        acc(0, 1, 16'h0072, 3'd6, 0, "R7 wbr ignored without burst", 0);
        // burst
        setcfg(16'h002A);
        acc(0, 1, 16'h0074, 3'd6, 0, "R6 burst", 0);
        setcfg(16'h006A);
        acc(0, 1, 16'h0076, 3'd6, 0, "R7 burst wait", 0);
        setcfg(16'h00AA);
        acc(0, 1, 16'h0078, 3'd6, 0, "R6 rbe ignored wide bus", 0);
        setcfg(16'h016A);
        acc(0, 1, 16'h007A, 3'd6, 0, "R3 R6 fast overrides burst", 0);
        // writes on narrow bus
        setcfg(16'h0009);
        acc(1, 1, 16'h0091, 3'd6, 16'h1234, "R5 R11 split write", 0);
        acc(0, 1, 16'h0090, 3'd6, 0, "R11 readback narrow", 0);
        setcfg(16'h0081);
        acc(1, 0, 16'h00A5, 3'd6, 16'h77C3, "R4 R11 byte write", 0);
        acc(0, 1, 16'h00A4, 3'd6, 0, "R4 R11 byte write readback", 0);
        // request while busy ignored
        setcfg(16'h0087);
        acc(0, 1, 16'h00B0, 3'd6, 0, "R9 long access with intrusion", 1);
        repeat (20) @(negedge clk);
        acc(0, 1, 16'h0080, 3'd6, 0, "R9 intruding write had no effect", 0);
        // reserved bits
        setcfg(16'hFFFF);
        @(negedge clk);
        chk(cfg_rdata == 16'h07FF, "R1 reserved bits", cfg_rdata, 16'h07FF);
        setcfg(16'hF800);
        @(negedge clk);
        chk(cfg_rdata == 16'h0000, "R1 reserved write", cfg_rdata, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule